// File: doc/BRIEF.md
# Compressor Timing Register Bank

This block is the software-facing register bank for an inline display-stream compressor. The compressor sits between a display controller and a serial display link. A simple register bus carries a byte address, separate write and read strobes, and 32-bit data. Through it, software programs the frame timing and image size, chooses command or video operation, and turns the core on.

Timing and size words go into shadow copies first. Nothing reaches the downstream timing generator until software writes the operation word with its update bit set. At that moment every shadow word is copied into the active set, so a frame never sees a half-programmed timing set.

A soft-reset bit clears all state and keeps reading back as 1 for a fixed number of cycles. It then drops by itself, so software can poll it to learn when the reset has finished.

Top module: `dsc_ctrl_regs`

## Requirements
- R1: After `rst_n` is released, `act_timing`, `op_ctrl` and `bus_rdata` are all zero and `reset_busy` is low.
- R2: A write to a timing word (byte offsets 0x08 to 0x30, word aligned, eleven words) changes only that word's shadow copy. `act_timing` keeps its value until an update is requested.
- R3: Writing offset 0x00 with bit 31 set copies all eleven shadow words into `act_timing`, and the copy is visible one cycle after the write. Word k of `act_timing` (bits 32k+31:32k) is offset 0x08+4k. Bit 31 is never stored and always reads back as 0.
- R4: Every timing word keeps only two 14-bit fields, bits 29:16 and 13:0. The exception is offset 0x24, the bitstream size, which keeps only bits 13:0. All other bits are stored as 0, and shadow words read back with the same masking.
- R5: Offset 0x04 reads back the `VERSION` parameter, and writes to it have no effect.
- R6: A read of any offset outside 0x00 to 0x30, or of an address whose low two bits are not zero, returns 0. A write to such an address changes nothing.
- R7: The operation word at 0x00 stores these bits: 30 (block on), 16 (bitstream-change output), 15:12 (video type), 5 (self refresh), 3 (full reset), 2 (core version control), 1 (command mode when 1) and 0 (core enable). They are presented on `op_ctrl` and read back from 0x00. All other bits are 0.
- R8: Writing 0x00 with bit 4 set starts a soft reset. For the next `RST_CYCLES` cycles, `reset_busy` is high and bit 4 of a read of 0x00 is 1. Shadow words, `act_timing` and `op_ctrl` are held at 0 during that time. After it, bit 4 reads 0 again.
- R9: Every write made while `reset_busy` is high is ignored.
- R10: Read data appears on `bus_rdata` on the cycle after the read strobe. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| act_timing | output | 352 | Eleven active timing words, word k for offset 0x08+4k |
| op_ctrl | output | 32 | Stored operation bits |
| reset_busy | output | 1 | Soft reset in progress |

## Verification
Three kinds of result fall due here, each a fixed number of clock edges after its stimulus. Read data and a committed active set each appear after exactly one rising edge. The busy flag stays up for exactly `RST_CYCLES` edges after the reset write.

The bench drives each bus operation at a falling edge and lets one rising edge pass. It then steps its reference model for that same edge and compares at the next falling edge. Every result is therefore judged in the cycle it becomes due, never earlier and never later. The soft-reset length is measured by counting the consecutive polled reads that show bit 4 set.

// File: rtl/dsc_ctrl_regs.sv
module dsc_ctrl_regs #(
  parameter int          ADDR_W     = 8,
  parameter int          FIELD_W    = 14,
  parameter int          RST_CYCLES = 16,
  parameter logic [31:0] VERSION    = 32'h0002_0100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [11*32-1:0]     act_timing,
  output logic [31:0]          op_ctrl,
  output logic                 reset_busy
);
  localparam int NTIM = 11;
  localparam int BS_IDX = 7;
  localparam int TW = $clog2(NTIM);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam int WW = ADDR_W - 2;
  localparam logic [WW-1:0] TIM_LO = WW'(2);
  localparam logic [WW-1:0] TIM_HI = WW'(2 + NTIM - 1);
  localparam logic [31:0] OP_MASK = 32'h4001_F02F;
  localparam logic [31:0] LO_MASK = 32'((64'd1 << FIELD_W) - 1);
  localparam logic [31:0] PAIR_MASK = LO_MASK | (LO_MASK << 16);

  logic [31:0] shadow_q [NTIM];
  logic [31:0] act_q    [NTIM];
  logic [31:0] op_q;
  logic [CW-1:0] cnt_q;
  logic [31:0] rd_mux;

  wire [WW-1:0] widx    = bus_addr[ADDR_W-1:2];
  wire          aligned = bus_addr[1:0] == 2'b00;
  wire          tim_hit = aligned && widx >= TIM_LO && widx <= TIM_HI;
  wire [TW-1:0] tsel    = TW'(widx - TIM_LO);
  wire          busy    = cnt_q != '0;
  wire          op_hit  = aligned && widx == '0;

  function automatic logic [31:0] tmask(input logic [TW-1:0] i);
    return (i == TW'(BS_IDX)) ? LO_MASK : PAIR_MASK;
  endfunction

  always_comb begin
    rd_mux = '0;
    if (op_hit)
      rd_mux = op_q | {27'b0, busy, 4'b0};
    else if (aligned && widx == WW'(1))
      rd_mux = VERSION;
    else if (tim_hit)
      rd_mux = shadow_q[tsel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      op_q      <= '0;
      bus_rdata <= '0;
      for (int i = 0; i < NTIM; i++) begin
        shadow_q[i] <= '0;
        act_q[i]    <= '0;
      end
    end else begin
      if (bus_rd)
        bus_rdata <= rd_mux;
      if (busy) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (bus_wr && op_hit) begin
        if (bus_wdata[4]) begin
          cnt_q <= CW'(RST_CYCLES);
          op_q  <= '0;
          for (int i = 0; i < NTIM; i++) begin
            shadow_q[i] <= '0;
            act_q[i]    <= '0;
          end
        end else begin
          op_q <= bus_wdata & OP_MASK;
          if (bus_wdata[31])
            for (int i = 0; i < NTIM; i++)
              act_q[i] <= shadow_q[i];
        end
      end else if (bus_wr && tim_hit) begin
        shadow_q[tsel] <= bus_wdata & tmask(tsel);
      end
    end
  end

  for (genvar g = 0; g < NTIM; g++) begin : g_out
    assign act_timing[g*32 +: 32] = act_q[g];
  end

  assign op_ctrl    = op_q;
  assign reset_busy = busy;
endmodule

// File: rtl/dsc_ctrl_regs_chk.sv
module dsc_ctrl_regs_chk #(
  parameter int          ADDR_W     = 8,
  parameter int          FIELD_W    = 14,
  parameter logic [31:0] VERSION    = 32'h0002_0100
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [11*32-1:0]  act_timing,
  input logic [31:0]       op_ctrl,
  input logic              reset_busy
);
  localparam logic [31:0] LO = 32'((64'd1 << FIELD_W) - 1);

  function automatic logic [11*32-1:0] act_mask();
    logic [11*32-1:0] m;
    for (int i = 0; i < 11; i++)
      m[i*32 +: 32] = (i == 7) ? LO : (LO | (LO << 16));
    return m;
  endfunction

  localparam logic [11*32-1:0] ACT_MASK = act_mask();

  wire op_wr = bus_wr && bus_addr == '0;

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(op_wr) |-> $stable(act_timing)); // R2

  AST_UPD_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && bus_addr == '0) |-> !bus_rdata[31]); // R3

  AST_FIELD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (act_timing & ~ACT_MASK) == '0); // R4

  AST_VERSION_RD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && bus_addr == ADDR_W'(4)) |-> bus_rdata == VERSION); // R5

  AST_MISALIGNED_RD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && bus_addr[1:0] != 2'b00) |-> bus_rdata == '0); // R6

  AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    reset_busy |-> (act_timing == '0 && op_ctrl == '0)); // R8

  AST_BUSY_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && bus_addr == '0 && reset_busy) |-> bus_rdata[4]); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata)); // R10
endmodule

bind dsc_ctrl_regs dsc_ctrl_regs_chk #(
  .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .VERSION(VERSION)
) u_chk (.*);

// File: tb/dsc_ctrl_regs_test.sv
`timescale 1ns/1ps
module dsc_ctrl_regs_test;
  localparam int RST = 16;
  localparam logic [31:0] VER = 32'h0002_0100;
  localparam logic [31:0] OPM = 32'h4001_F02F;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, op_ctrl;
  logic [11*32-1:0] act_timing;
  logic reset_busy;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_sh [11];
  logic [31:0] m_act [11];
  logic [31:0] m_op;
  int m_busy;

  always #10 clk = ~clk;

  dsc_ctrl_regs uut (.*);

  function automatic logic [31:0] tmask(int i);
    return (i == 7) ? 32'h0000_3FFF : 32'h3FFF_3FFF;
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    if (a[1:0] != 0) return 0;
    if (a == 0) return m_op | ((m_busy > 0) ? 32'h10 : 0);
    if (a == 8'h04) return VER;
    if (a >= 8'h08 && a <= 8'h30) return m_sh[(a - 8) / 4];
    return 0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step(bit w, logic [7:0] a, logic [31:0] d);
    if (m_busy > 0) m_busy--;
    else if (w && a[1:0] == 0) begin
      if (a == 0) begin
        if (d[4]) begin
          m_busy = RST; m_op = 0;
          for (int i = 0; i < 11; i++) begin m_sh[i] = 0; m_act[i] = 0; end
        end else begin
          m_op = d & OPM;
          if (d[31]) for (int i = 0; i < 11; i++) m_act[i] = m_sh[i];
        end
      end else if (a >= 8'h08 && a <= 8'h30)
        m_sh[(a - 8) / 4] = d & tmask((a - 8) / 4);
    end
  endtask

  task automatic bus(bit w, bit r, logic [7:0] a, logic [31:0] d, string tag);
    logic [31:0] er = model_read(a);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_step(w, a, d);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    if (r) chk(tag, bus_rdata, er);
    for (int i = 0; i < 11; i++) chk("R2 active word", act_timing[i*32 +: 32], m_act[i]);
    chk("R7 op_ctrl", op_ctrl, m_op);
    chk("R8 busy", {31'b0, reset_busy}, {31'b0, m_busy > 0});
  endtask

  initial begin
    m_op = 0; m_busy = 0;
    for (int i = 0; i < 11; i++) begin m_sh[i] = 0; m_act[i] = 0; end
    void'($urandom(32'd77));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 act", act_timing[31:0] | act_timing[351:320], 0);
    chk("R1 op", op_ctrl, 0);
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 busy", {31'b0, reset_busy}, 0);

    bus(1, 0, 8'h08, 32'hFFFF_FFFF, "R2");
    bus(1, 0, 8'h24, 32'hFFFF_FFFF, "R4");
    bus(1, 0, 8'h30, 32'h1234_5678, "R4");
    chk("R2 no effect before update", act_timing[31:0], 0);
    bus(0, 1, 8'h08, 0, "R4 pair mask");
    chk("R4 pair readback", bus_rdata, 32'h3FFF_3FFF);
    bus(0, 1, 8'h24, 0, "R4 bs mask");
    chk("R4 bs readback", bus_rdata, 32'h0000_3FFF);
    bus(1, 0, 8'h00, 32'h8000_0001, "R3");
    chk("R3 commit word0", act_timing[31:0], 32'h3FFF_3FFF);
    chk("R3 commit word7", act_timing[7*32 +: 32], 32'h0000_3FFF);
    bus(0, 1, 8'h00, 0, "R3 update bit reads 0");
    bus(1, 0, 8'h00, 32'hFFFF_FFEF, "R7");
    chk("R7 op fields", op_ctrl, OPM);
    bus(1, 0, 8'h00, 32'h0000_0002, "R7");
    chk("R7 cmd mode only", op_ctrl, 32'h2);

    bus(1, 0, 8'h04, 32'hDEAD_BEEF, "R5");
    bus(0, 1, 8'h04, 0, "R5 version");
    chk("R5 version value", bus_rdata, VER);
    bus(0, 1, 8'h34, 0, "R6 unmapped 0x34");
    bus(0, 1, 8'h44, 0, "R6 unmapped 0x44");
    bus(0, 1, 8'h0A, 0, "R6 misaligned");
    bus(1, 0, 8'h0A, 32'h0000_0123, "R6");
    bus(1, 0, 8'hFC, 32'h0000_0123, "R6");
    bus(0, 1, 8'h08, 0, "R6 write ignored");
    chk("R6 shadow unchanged", bus_rdata, 32'h3FFF_3FFF);

    bus(0, 1, 8'h30, 0, "R10");
    bus(0, 0, 8'h00, 0, "R10");
    chk("R10 rdata holds", bus_rdata, 32'h1234_1678 & 32'h3FFF_3FFF);

    bus(1, 0, 8'h00, 32'h0000_0010, "R8");
    begin
      int polls = 0;
      bus(1, 0, 8'h08, 32'h0000_0055, "R9");
      bus(1, 0, 8'h00, 32'h8000_0001, "R9");
      polls = 2;
      while (reset_busy && polls < 100) begin
        bus(0, 1, 8'h00, 0, "R8 poll");
        if (bus_rdata[4]) polls++;
      end
      chk("R8 busy length", polls, RST);
    end
    bus(0, 1, 8'h08, 0, "R9 write during reset ignored");
    chk("R9 shadow zero", bus_rdata, 0);
    chk("R9 op zero", op_ctrl, 0);

    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      logic [31:0] d = $urandom;
      int s = $urandom % 16;
      if (s < 11) a = 8'(8 + 4 * s);
      else if (s == 11) a = 8'h00;
      else if (s == 12) a = 8'h04;
      else if (s == 13) a = 8'h40;
      else if (s == 14) a = 8'h0E;
      else a = 8'h00;
      if (a == 0 && ($urandom % 12) != 0) d[4] = 0;
      bus($urandom % 2, $urandom % 2, a, d, "R4 random read");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule